// File: doc/BRIEF.md
# GPIO Interrupt Routing Multiplexer

This block carries the per-line interrupt requests of three GPIO controllers to the processor's interrupt inputs. There are 70 lines in all: 14 from controller 0, 24 from controller 1 and 32 from controller 2. The processor side has 38 dedicated inputs and 3 shared inputs. A 32-bit mux control register decides, at each of 32 mux positions, which of two competing lines gets the dedicated input.

At positions 0 to 13 the contest is between controller 0 line p and controller 2 line p. At positions 14 to 31 it is between controller 1 line p-14 and controller 2 line p. The line that loses a position is still delivered: it is ORed into the shared input of its own controller. The six upper lines of controller 1 (18 to 23) are never muxed and always have their own dedicated inputs.

Software reaches the register through a small read/write port at byte offset 0x54. After reset the register holds 0. Software writes the routing once, and can read it back at any time.

Top module: `gpio_irq_router`

## Requirements
- R1: A synchronous active-high reset clears the mux control register to 0, and the read port then returns 0.
- R2: A write with `reg_wr` high and `reg_addr` equal to 0x54 stores `reg_wdata`. A write to any other address leaves the register unchanged. Read data is registered: one cycle after an address is presented, `reg_rdata` holds the register if the address is 0x54, and 0 for any other address.
- R3: For mux position p in 0..13, `ded_irq[p]` carries `gp2_irq[p]` when control bit p is 1, and `gp0_irq[p]` when it is 0.
- R4: For mux position p in 14..31, `ded_irq[p]` carries `gp2_irq[p]` when control bit p is 1, and `gp1_irq[p-14]` when it is 0.
- R5: `ded_irq[32+j]` carries `gp1_irq[18+j]` for j in 0..5, whatever the register holds.
- R6: `shr_irq[0]` is the OR of every `gp0_irq[p]` whose control bit p is 1.
- R7: `shr_irq[1]` is the OR of every `gp1_irq[p-14]` whose control bit p (p in 14..31) is 1. Lines 18..23 of controller 1 never reach it.
- R8: `shr_irq[2]` is the OR of every `gp2_irq[p]` whose control bit p is 0.
- R9: Routing is combinational from the register and the lines. A new register value takes effect in the cycle after the clock edge that accepts the write, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| gp0_irq | input | 14 | Interrupt lines of controller 0 |
| gp1_irq | input | 24 | Interrupt lines of controller 1 |
| gp2_irq | input | 32 | Interrupt lines of controller 2 |
| ded_irq | output | 38 | Dedicated interrupt outputs: 0..31 are the mux positions, 32..37 are the fixed controller 1 lines |
| shr_irq | output | 3 | Shared interrupt outputs, index = controller number |

## Verification
The mux control register is the only state in the block. A wrong bit in it does not show up by itself: it shows only when the two lines competing at that position differ, or when the losing line is active. In that case the fault appears on a dedicated output and on a shared output in the same cycle. It is also visible on the read port one cycle after the register address is presented. For this reason the stimulus sets the two sides of each position to different values across many register values. Each write is checked in the first cycle after the edge that accepts it.

// File: rtl/gir_pkg.sv
package gir_pkg;
  // Index of each controller's shared output
  localparam int unsigned SH_C0    = 0;
  localparam int unsigned SH_C1    = 1;
  localparam int unsigned SH_C2    = 2;
  localparam int unsigned N_SHARED = 3;
endpackage

// File: rtl/gir_ctrl_reg.sv
module gir_ctrl_reg #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFFSET = 12'h054
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] rdata
);
  logic hit;
  assign hit = (addr == OFFSET);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en && hit) ctrl_q <= wdata;
      rdata <= hit ? ctrl_q : '0;
    end
  end

  // R1: reset leaves the register and the read data at zero
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ctrl_q == '0 && rdata == '0));

  // R2: an accepted write lands in the register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit) |=> ctrl_q == $past(wdata));

  // R2: without an accepted write the register holds its value
  a_r2_miss_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && hit) |=> $stable(ctrl_q));
endmodule

// File: rtl/gir_lane.sv
module gir_lane (
  input  logic sel,
  input  logic a_line,
  input  logic b_line,
  output logic ded,
  output logic a_shared,
  output logic b_shared
);
  // sel = 1: the B side (controller 2) wins the dedicated output
  always_comb begin
    ded      = sel ? b_line : a_line;
    a_shared = sel & a_line;
    b_shared = ~sel & b_line;
  end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int unsigned N0_LINES = 14,
  parameter int unsigned N1_LINES = 24,
  parameter int unsigned N2_LINES = 32,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h054
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [N2_LINES-1:0]          reg_wdata,
  output logic [N2_LINES-1:0]          reg_rdata,
  input  logic [N0_LINES-1:0]          gp0_irq,
  input  logic [N1_LINES-1:0]          gp1_irq,
  input  logic [N2_LINES-1:0]          gp2_irq,
  output logic [N0_LINES+N1_LINES-1:0] ded_irq,
  output logic [gir_pkg::N_SHARED-1:0] shr_irq
);
  localparam int unsigned MUX_POS = N2_LINES;           // mux positions = register width
  localparam int unsigned MUX1    = N2_LINES - N0_LINES; // controller 1 lines that are muxed
  localparam int unsigned FIX1    = N1_LINES - MUX1;     // controller 1 lines with a fixed output

  logic [MUX_POS-1:0] ctrl_q;
  logic [MUX_POS-1:0] a_line, a_sh, b_sh;

  gir_ctrl_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (MUX_POS),
    .OFFSET (CTRL_OFFSET)
  ) u_reg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .ctrl_q (ctrl_q),
    .rdata  (reg_rdata)
  );

  for (genvar p = 0; p < MUX_POS; p++) begin : g_pos
    if (p < N0_LINES) begin : g_c0
      assign a_line[p] = gp0_irq[p];
    end else begin : g_c1
      assign a_line[p] = gp1_irq[p-N0_LINES];
    end
    gir_lane u_lane (
      .sel      (ctrl_q[p]),
      .a_line   (a_line[p]),
      .b_line   (gp2_irq[p]),
      .ded      (ded_irq[p]),
      .a_shared (a_sh[p]),
      .b_shared (b_sh[p])
    );
  end

  for (genvar j = 0; j < FIX1; j++) begin : g_fix
    assign ded_irq[MUX_POS+j] = gp1_irq[MUX1+j];
  end

  assign shr_irq[gir_pkg::SH_C0] = |a_sh[N0_LINES-1:0];
  assign shr_irq[gir_pkg::SH_C1] = |a_sh[MUX_POS-1:N0_LINES];
  assign shr_irq[gir_pkg::SH_C2] = |b_sh;

  // R6: the controller 0 shared output needs an active controller 0 line
  a_r6_shared0_has_source: assert property (@(posedge clk) disable iff (rst)
    shr_irq[gir_pkg::SH_C0] |-> (|gp0_irq));

  // R7: with the register at zero, controllers 0 and 1 have no shared traffic
  a_r7_zero_reg_quiet: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q == '0) |-> (shr_irq[gir_pkg::SH_C1:gir_pkg::SH_C0] == 2'b00));

  // R8: with every bit set, controller 2 is fully dedicated
  a_r8_all_ones_quiet: assert property (@(posedge clk) disable iff (rst)
    (&ctrl_q) |-> !shr_irq[gir_pkg::SH_C2]);
endmodule

// File: tb/sim_gpio_irq_router.sv
module sim_gpio_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] OFS = 12'h054;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [13:0] gp0_irq = '0;
  logic [23:0] gp1_irq = '0;
  logic [31:0] gp2_irq = '0;
  logic [37:0] ded_irq;
  logic [2:0]  shr_irq;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_router u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .gp0_irq(gp0_irq), .gp1_irq(gp1_irq), .gp2_irq(gp2_irq),
    .ded_irq(ded_irq), .shr_irq(shr_irq)
  );

  // Stimulus table: {register, controller 0, controller 1, controller 2}
  localparam logic [101:0] VEC [8] = '{
    {32'h0000_0000, 14'h3FFF, 24'h000000, 32'h0000_0000},
    {32'hFFFF_FFFF, 14'h3FFF, 24'hFFFFFF, 32'h0000_0000},
    {32'hFFFF_FFFF, 14'h0000, 24'h000000, 32'hFFFF_FFFF},
    {32'h0000_0000, 14'h0000, 24'hFC0000, 32'h8000_0001},
    {32'hAAAA_AAAA, 14'h1555, 24'h2AAAAA, 32'h5555_5555},
    {32'h0000_3FFF, 14'h2001, 24'h020001, 32'hC000_0000},
    {32'hFFFF_C000, 14'h0001, 24'h000001, 32'h0000_2000},
    {32'h8000_2000, 14'h2000, 24'h020000, 32'h0000_0000}
  };

  // Reference mapping, written from the requirements
  function automatic logic [40:0] model(logic [31:0] m, logic [13:0] a,
                                        logic [23:0] b, logic [31:0] c);
    logic [37:0] d;
    logic [2:0]  s;
    s = '0;
    d = '0;
    for (int p = 0; p < 32; p++) begin
      logic own;
      own = (p < 14) ? a[p] : b[p-14];
      if (m[p]) begin
        d[p] = c[p];
        if (p < 14) s[0] = s[0] | own;
        else        s[1] = s[1] | own;
      end else begin
        d[p] = own;
        s[2] = s[2] | c[p];
      end
    end
    for (int f = 0; f < 6; f++) d[32+f] = b[18+f];
    return {s, d};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic lines(input logic [13:0] a, input logic [23:0] b, input logic [31:0] c);
    gp0_irq = a; gp1_irq = b; gp2_irq = c;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] cur;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 rdata after reset", {32'h0, reg_rdata}, 64'h0);
    rst = 1'b0;
    lines(14'h3FFF, 24'h000000, 32'hFFFF_FFFF);
    chk("R1 routing at reset", {23'h0, shr_irq, ded_irq}, {23'h0, model(32'h0, 14'h3FFF, 24'h0, 32'hFFFF_FFFF)});
    rd(OFS, rv);
    chk("R1 readback after reset", {32'h0, rv}, 64'h0);

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 8; i++) begin
      logic [101:0] v;
      v = VEC[i];
      wr(OFS, v[101:70]);
      lines(v[69:56], v[55:32], v[31:0]);
      chk("R3/R4/R5/R6/R7/R8 table", {23'h0, shr_irq, ded_irq},
          {23'h0, model(v[101:70], v[69:56], v[55:32], v[31:0])});
      rd(OFS, rv);
      chk("R2 table readback", {32'h0, rv}, {32'h0, v[101:70]});
    end

    // R2: writes to other addresses are ignored; reads elsewhere return 0
    wr(OFS, 32'h1234_5678);
    wr(12'h050, 32'hFFFF_FFFF);
    wr(12'h058, 32'h0000_0000);
    rd(OFS, rv);
    chk("R2 miss write ignored", {32'h0, rv}, 64'h1234_5678);
    lines(14'h3FFF, 24'hFFFFFF, 32'h0);
    chk("R2 miss write routing", {23'h0, shr_irq, ded_irq},
        {23'h0, model(32'h1234_5678, 14'h3FFF, 24'hFFFFFF, 32'h0)});
    rd(12'h050, rv);
    chk("R2 other address reads zero", {32'h0, rv}, 64'h0);

    // R5 and R7: fixed lines never muxed and never shared
    wr(OFS, 32'hFFFF_FFFF);
    lines(14'h0, 24'hFC0000, 32'h0);
    chk("R5 fixed lines with all ones", {58'h0, ded_irq[37:32]}, 64'h3F);
    chk("R7 fixed lines not shared", {63'h0, shr_irq[1]}, 64'h0);
    wr(OFS, 32'h0);
    chk("R5 fixed lines with zero", {58'h0, ded_irq[37:32]}, 64'h3F);

    // R9: a write takes effect only after its edge
    lines(14'h0001, 24'h0, 32'h0000_0000);
    cur = 32'h0;
    reg_wr = 1'b1; reg_addr = OFS; reg_wdata = 32'h0000_0001;
    #1;
    chk("R9 old routing before edge", {62'h0, ded_irq[0], shr_irq[0]}, {62'h0, 1'b1, 1'b0});
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
    chk("R9 new routing after edge", {62'h0, ded_irq[0], shr_irq[0]}, {62'h0, 1'b0, 1'b1});
    cur = 32'h0000_0001;

    // Random register values and line patterns
    for (int n = 0; n < 300; n++) begin
      logic [31:0] m;
      logic [13:0] a;
      logic [23:0] b;
      logic [31:0] c;
      m = $urandom; a = 14'($urandom); b = 24'($urandom); c = $urandom;
      if (n % 3 == 0) begin
        wr(OFS, m);
        cur = m;
      end else begin
        @(negedge clk);
      end
      lines(a, b, c);
      chk("R3/R4/R6/R7/R8 random", {23'h0, shr_irq, ded_irq}, {23'h0, model(cur, a, b, c)});
    end

    // R1: reset mid-run clears the register again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(OFS, rv);
    chk("R1 reset after use", {32'h0, rv}, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule